// File: doc/BRIEF.md
# Touch Converter Serial Reply Engine

This block is the device side of a touchscreen converter that talks over a serial link one byte at a time. On every byte exchange the host shifts a byte in and the block shifts a reply byte back. A byte whose top bit is set is a command. It selects a measurement channel. The next two exchanges return the 12-bit result for that channel, split into a high byte and a low byte. After that the block returns zero until a new command arrives.

The analog side is not part of this block. The X and Y samples arrive on input ports as finished 12-bit values, together with a pen-down flag. The pen flag decides what the X and Y channels report. Every other channel reports zero. When the chip select is released without hold, the stored command is dropped.

The reply for an exchange depends only on the state held before that exchange's incoming byte. So the exchange that carries a command still returns whatever the previous state called for.

Top module: `tadc_resp`

## Requirements
- R1: After reset, `rsp_valid` and `rsp_byte` are 0 and no command is stored, so every reply is 0 until a command byte arrives.
- R2: Every cycle with `xfer_valid` high is followed, on the next cycle only, by `rsp_valid` high carrying that exchange's reply; `rsp_valid` is low otherwise.
- R3: An incoming byte with bit 7 set is stored as the command and restarts the reply sequence; the reply to that same exchange comes from the state before it.
- R4: The first reply after a command carries result bits 11..5 in reply bits 6..0, with bit 7 zero.
- R5: The second reply carries result bits 4..0 in reply bits 7..3, with bits 2..0 zero.
- R6: Every reply after the second is 0 until a new command byte is received.
- R7: The channel is command bits 6..4: value 5 selects X and value 1 selects Y. Values 0, 2, 3, 4, 6 and 7 report a result of 0.
- R8: With `pen_down` low, X reports 0x000 and Y reports 0xFFF.
- R9: With `pen_down` high, X reports `raw_x` + 0x100 and Y reports `raw_y` + 0x0B0, both modulo 4096.
- R10: The result is captured in the cycle that produces the first reply. Changes to `pen_down`, `raw_x` or `raw_y` after that cycle do not alter the second reply.
- R11: A `desel` pulse clears the stored command and the sequence position, so the following replies are 0. If `desel` arrives together with a command byte, `desel` wins and the command is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_valid | input | 1 | One byte exchange completes in this cycle |
| xfer_din | input | 8 | Byte received from the host |
| desel | input | 1 | Chip select released without hold (pulse) |
| pen_down | input | 1 | Pen touching the panel |
| raw_x | input | 12 | Ready-made X sample |
| raw_y | input | 12 | Ready-made Y sample |
| rsp_valid | output | 1 | Reply byte is valid (one cycle) |
| rsp_byte | output | 8 | Reply byte for the last exchange |

## Verification
The assertions assume that `xfer_valid` and `desel` are single-cycle qualifiers. They also assume that reset is held for at least one clock before any exchange, so that no history from before reset is used. The bench drives every input on the falling edge and holds `xfer_valid` low during reset. It issues each exchange as a one-cycle pulse, with at least one idle cycle after it. Random stimulus draws command bytes that favour the X and Y channels. It also draws data bytes and flips the pen flag and samples between exchanges. Now and then it adds a deselect, sometimes in the same cycle as a command byte.

// File: rtl/tadc_pkg.sv
package tadc_pkg;

    parameter int unsigned BYTE_W   = 8;
    parameter int unsigned RES_W    = 12;
    parameter int unsigned CH_W     = 3;
    parameter int unsigned CH_LSB   = 4;
    parameter int unsigned LO_SHIFT = 3;

    localparam int unsigned HI_W = BYTE_W - 1;
    localparam int unsigned LO_W = RES_W - HI_W;

    // position in the two-byte readout
    typedef enum logic [1:0] {
        PH_FRESH   = 2'd0,
        PH_HI_SENT = 2'd1,
        PH_DONE    = 2'd2
    } phase_e;

    // what the current exchange returns
    typedef enum logic [1:0] {
        RK_ZERO = 2'd0,
        RK_HI   = 2'd1,
        RK_LO   = 2'd2
    } kind_e;

    typedef enum logic [CH_W-1:0] {
        CH_TEMP_A = 3'd0,
        CH_POS_Y  = 3'd1,
        CH_BATT   = 3'd2,
        CH_PRES_A = 3'd3,
        CH_PRES_B = 3'd4,
        CH_POS_X  = 3'd5,
        CH_AUDIO  = 3'd6,
        CH_TEMP_B = 3'd7
    } chan_e;

    function automatic logic is_cmd(input logic [BYTE_W-1:0] b);
        return b[BYTE_W-1];
    endfunction

    function automatic chan_e chan_of(input logic [BYTE_W-1:0] b);
        return chan_e'(b[CH_LSB +: CH_W]);
    endfunction

    function automatic logic [BYTE_W-1:0] frame_hi(input logic [RES_W-1:0] r);
        return {1'b0, r[RES_W-1 -: HI_W]};
    endfunction

    function automatic logic [BYTE_W-1:0] frame_lo(input logic [RES_W-1:0] r);
        return BYTE_W'({r[LO_W-1:0], {LO_SHIFT{1'b0}}});
    endfunction

endpackage

// File: rtl/tadc_cmd_track.sv
module tadc_cmd_track
    import tadc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_valid,
    input  logic [BYTE_W-1:0] xfer_din,
    input  logic              desel,
    output logic [BYTE_W-1:0] cmd_q,
    output phase_e            phase_q,
    output kind_e             kind
);

    always_comb begin
        unique case (phase_q)
            PH_HI_SENT: kind = RK_LO;
            PH_DONE:    kind = RK_ZERO;
            default:    kind = is_cmd(cmd_q) ? RK_HI : RK_ZERO;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            phase_q <= PH_FRESH;
        end else if (desel) begin
            cmd_q   <= '0;
            phase_q <= PH_FRESH;
        end else if (xfer_valid) begin
            if (is_cmd(xfer_din)) begin
                cmd_q   <= xfer_din;
                phase_q <= PH_FRESH;
            end else begin
                unique case (kind)
                    RK_HI:   phase_q <= PH_HI_SENT;
                    RK_LO:   phase_q <= PH_DONE;
                    default: phase_q <= phase_q;
                endcase
            end
        end
    end

    // R3: a command byte is stored and the readout restarts
    p_cmd_store_r3: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && !desel && xfer_din[BYTE_W-1])
        |=> (cmd_q == $past(xfer_din)) && (phase_q == PH_FRESH));

    // R11: deselect empties the command register
    p_desel_clear_r11: assert property (@(posedge clk) disable iff (rst)
        desel |=> (cmd_q == '0) && (phase_q == PH_FRESH));

    // R6: once done, only a command or deselect leaves the done state
    p_done_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DONE && !desel && !(xfer_valid && xfer_din[BYTE_W-1]))
        |=> phase_q == PH_DONE);

endmodule

// File: rtl/tadc_chan_sel.sv
module tadc_chan_sel
    import tadc_pkg::*;
#(
    parameter logic [RES_W-1:0] X_OFFSET = 12'h100,
    parameter logic [RES_W-1:0] Y_OFFSET = 12'h0B0,
    parameter logic [RES_W-1:0] Y_IDLE   = 12'hFFF
) (
    input  chan_e            chan,
    input  logic             pen_down,
    input  logic [RES_W-1:0] raw_x,
    input  logic [RES_W-1:0] raw_y,
    output logic [RES_W-1:0] result
);

    always_comb begin
        unique case (chan)
            CH_POS_X: result = pen_down ? RES_W'(raw_x + X_OFFSET) : '0;
            CH_POS_Y: result = pen_down ? RES_W'(raw_y + Y_OFFSET) : Y_IDLE;
            default:  result = '0;
        endcase
    end

endmodule

// File: rtl/tadc_reply_fmt.sv
module tadc_reply_fmt
    import tadc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_valid,
    input  kind_e             kind,
    input  logic [RES_W-1:0]  result,
    output logic [RES_W-1:0]  res_q,
    output logic              rsp_valid,
    output logic [BYTE_W-1:0] rsp_byte
);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_byte  <= '0;
        end else begin
            rsp_valid <= xfer_valid;
            if (xfer_valid) begin
                unique case (kind)
                    RK_HI: begin
                        res_q    <= result;
                        rsp_byte <= frame_hi(result);
                    end
                    RK_LO:   rsp_byte <= frame_lo(res_q);
                    default: rsp_byte <= '0;
                endcase
            end
        end
    end

    // R2: a reply follows each exchange by exactly one cycle
    p_rsp_follow_r2: assert property (@(posedge clk) disable iff (rst)
        $past(xfer_valid && !rst) == rsp_valid);

    // R4: high reply never sets the top bit
    p_hi_msb_r4: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && kind == RK_HI) |=> rsp_byte[BYTE_W-1] == 1'b0);

    // R5: low reply keeps its pad bits clear
    p_lo_pad_r5: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && kind == RK_LO) |=> rsp_byte[LO_SHIFT-1:0] == '0);

endmodule

// File: rtl/tadc_resp.sv
module tadc_resp
    import tadc_pkg::*;
#(
    parameter logic [RES_W-1:0] X_OFFSET = 12'h100,
    parameter logic [RES_W-1:0] Y_OFFSET = 12'h0B0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_valid,
    input  logic [BYTE_W-1:0] xfer_din,
    input  logic              desel,
    input  logic              pen_down,
    input  logic [RES_W-1:0]  raw_x,
    input  logic [RES_W-1:0]  raw_y,
    output logic              rsp_valid,
    output logic [BYTE_W-1:0] rsp_byte
);

    logic [BYTE_W-1:0] cmd_q;
    phase_e            phase_q;
    kind_e             kind;
    logic [RES_W-1:0]  result;
    logic [RES_W-1:0]  res_q;

    tadc_cmd_track u_track (
        .clk        (clk),
        .rst        (rst),
        .xfer_valid (xfer_valid),
        .xfer_din   (xfer_din),
        .desel      (desel),
        .cmd_q      (cmd_q),
        .phase_q    (phase_q),
        .kind       (kind)
    );

    tadc_chan_sel #(
        .X_OFFSET (X_OFFSET),
        .Y_OFFSET (Y_OFFSET),
        .Y_IDLE   ({RES_W{1'b1}})
    ) u_sel (
        .chan     (chan_of(cmd_q)),
        .pen_down (pen_down),
        .raw_x    (raw_x),
        .raw_y    (raw_y),
        .result   (result)
    );

    tadc_reply_fmt u_fmt (
        .clk        (clk),
        .rst        (rst),
        .xfer_valid (xfer_valid),
        .kind       (kind),
        .result     (result),
        .res_q      (res_q),
        .rsp_valid  (rsp_valid),
        .rsp_byte   (rsp_byte)
    );

    // R10: captured result holds while the low reply is pending
    p_res_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_HI_SENT && $past(phase_q == PH_HI_SENT && !rst))
        |-> $stable(res_q));

    // R6: exchanges after the readout return zero
    p_zero_after_r6: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && phase_q == PH_DONE) |=> rsp_byte == '0);

    // R1: without a stored command, replies are zero
    p_no_cmd_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && cmd_q == '0 && phase_q == PH_FRESH) |=> rsp_byte == '0);

endmodule

// File: tb/test_tadc_resp.sv
`timescale 1ns/1ps
module test_tadc_resp;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xfer_valid = 1'b0;
    logic [7:0]  xfer_din = '0;
    logic        desel = 1'b0;
    logic        pen_down = 1'b0;
    logic [11:0] raw_x = '0;
    logic [11:0] raw_y = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_byte;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    // bench model of stored state
    logic [7:0]  m_cmd = '0;
    int          m_ph = 0;     // 0 fresh, 1 high sent, 2 done
    logic [11:0] m_res = '0;

    always #10 clk = ~clk;

    tadc_resp i_tadc_resp (
        .clk(clk), .rst(rst), .xfer_valid(xfer_valid), .xfer_din(xfer_din),
        .desel(desel), .pen_down(pen_down), .raw_x(raw_x), .raw_y(raw_y),
        .rsp_valid(rsp_valid), .rsp_byte(rsp_byte)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [11:0] exp_result(input logic [7:0] c, input logic pd,
                                               input logic [11:0] x, input logic [11:0] y);
        case (c[6:4])
            3'd5:    return pd ? 12'(x + 12'h100) : 12'h000;
            3'd1:    return pd ? 12'(y + 12'h0B0) : 12'hFFF;
            default: return 12'h000;
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one exchange, then one idle cycle
    task automatic xfer(input logic [7:0] b, input logic ds, input string tag);
        logic [7:0] e;
        @(negedge clk);
        if (m_ph == 1) begin
            e = {m_res[4:0], 3'b000};
            m_ph = 2;
        end else if (m_ph == 2 || !m_cmd[7]) begin
            e = 8'h00;
        end else begin
            m_res = exp_result(m_cmd, pen_down, raw_x, raw_y);
            e = {1'b0, m_res[11:5]};
            m_ph = 1;
        end
        if (ds) begin
            m_cmd = '0; m_ph = 0;
        end else if (b[7]) begin
            m_cmd = b; m_ph = 0;
        end
        xfer_valid = 1'b1; xfer_din = b; desel = ds;
        @(negedge clk);
        xfer_valid = 1'b0; desel = 1'b0;
        check({tag, " R2 valid"}, {7'd0, rsp_valid}, 8'd1);
        check(tag, rsp_byte, e);
        @(negedge clk);
        check("R2 idle", {7'd0, rsp_valid}, 8'd0);
    endtask

    task automatic pulse_desel();
        @(negedge clk);
        desel = 1'b1; m_cmd = '0; m_ph = 0;
        @(negedge clk);
        desel = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset valid", {7'd0, rsp_valid}, 8'd0);
        check("R1 reset byte", rsp_byte, 8'h00);
        xfer(8'h00, 1'b0, "R1 no command");
        xfer(8'h3C, 1'b0, "R1 no command");

        // X with pen down, offset wraps modulo 4096
        pen_down = 1'b1; raw_x = 12'hF50;
        xfer(8'hD0, 1'b0, "R3 command echo");
        xfer(8'h00, 1'b0, "R4 R9 X high");
        xfer(8'h00, 1'b0, "R5 R9 X low");
        xfer(8'h00, 1'b0, "R6 trailing");
        xfer(8'h11, 1'b0, "R6 trailing");

        // pen up X and Y
        pen_down = 1'b0;
        xfer(8'hD3, 1'b0, "R3 command echo");
        xfer(8'h00, 1'b0, "R8 X up high");
        xfer(8'h90, 1'b0, "R8 X up low");
        xfer(8'h00, 1'b0, "R8 Y up high");
        xfer(8'h00, 1'b0, "R8 Y up low");

        // unsupported channel
        pen_down = 1'b1;
        xfer(8'hB4, 1'b0, "R3 command echo");
        xfer(8'h00, 1'b0, "R7 unsupported high");
        xfer(8'h00, 1'b0, "R7 unsupported low");

        // capture on high reply; change inputs before low
        raw_y = 12'h5A5;
        xfer(8'h9F, 1'b0, "R3 command echo");
        xfer(8'h00, 1'b0, "R9 Y high");
        raw_y = 12'h000; pen_down = 1'b0;
        xfer(8'h00, 1'b0, "R10 Y low after change");

        // restart mid readout
        pen_down = 1'b1; raw_x = 12'h123;
        xfer(8'hD0, 1'b0, "R3 command echo");
        xfer(8'h00, 1'b0, "R4 X high");
        xfer(8'h90, 1'b0, "R3 restart returns low");
        xfer(8'h00, 1'b0, "R3 fresh high");

        // deselect clears
        xfer(8'hD0, 1'b0, "R3 command echo");
        pulse_desel();
        xfer(8'h00, 1'b0, "R11 after desel");
        xfer(8'hD0, 1'b1, "R11 desel beats command");
        xfer(8'h00, 1'b0, "R11 command dropped");

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [7:0] b;
            int r;
            r = int'($urandom_range(0, 9));
            pen_down = 1'($urandom_range(0, 1));
            raw_x = 12'($urandom);
            raw_y = 12'($urandom);
            if (r < 3) b = ($urandom_range(0, 1) != 0) ? 8'hD0 : 8'h90;
            else if (r < 4) b = 8'($urandom) | 8'h80;
            else b = 8'($urandom) & 8'h7F;
            if (r == 9 && i % 3 == 0) pulse_desel();
            xfer(b, (i % 41) == 0, "R4 R5 R6 R9 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule